// File: doc/BRIEF.md
# Jump-or-Do Microprogram Sequencer

This block is a small microcoded controller. A 5-bit micro-program counter addresses a 32-entry program store of 8-bit microwords. The program store is a parameter of the block. On each rising clock edge the sequencer picks the next micro-address from the word it is on and from a one-bit condition input `z` that comes from the datapath. The block does not include the datapath that its control bits steer.

Every microword is one of two kinds, chosen by its top bit:

- A **do** word drives the datapath. Its seven low bits are copied into the control register.
- A **jump** word tests `z` with a 2-bit condition code. When the test passes, it loads a 5-bit target into the micro-PC.

The control register loads only on the falling clock edge. It keeps its value while a jump word executes. This lets a program spin in a polling loop without glitching its outputs. Bit 0 of the control register is the output of the emulated state machine. The default program emulates a six-state Moore machine, spending three or four microwords per state.

The sequencer moves in one of three named steps each rising edge:

- **STEP_ADVANCE** (do word): the micro-PC increments.
- **STEP_BRANCH** (jump word whose test passes): the micro-PC takes the target.
- **STEP_SKIP** (jump word whose test fails): the micro-PC increments.

Top module: `useq_top`

## Requirements
- R1: While `rst_n` is low, `upc` is 0 and `ctl` is 0.
- R2: A word with bit 7 = 0 (do word) makes `upc` increment by one at the next rising edge.
- R3: A word with bit 7 = 1 and bits 6:5 = 00 loads bits 4:0 into `upc` at the next rising edge if `z` = 1, and otherwise increments `upc`.
- R4: A jump word with bits 6:5 = 01 loads its target if `z` = 0, and otherwise increments `upc`.
- R5: A jump word with bits 6:5 = 11 always loads its target, whatever `z` is.
- R6: A jump word with bits 6:5 = 10 never branches: `upc` increments, whatever `z` and the target bits are.
- R7: Incrementing from address 31 gives address 0.
- R8: At each falling edge while a do word is current, `ctl` takes bits 6:0 of that word. Bit 0 is the emulated machine's output.
- R9: At a falling edge while a jump word is current, `ctl` keeps its previous value.
- R10: `ctl` never changes at a rising edge.
- R11: Running the default program with input sequence 1,0,1,1,0,1 on `z` yields the `upc` and `ctl` trace that a behavioural interpreter of R2 to R9 predicts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the sequencer uses the rising edge, the control register the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| z | input | 1 | Condition bit from the datapath, sampled at the rising edge |
| ctl | output | 7 | Registered control bits; bit 0 is the emulated machine output |
| upc | output | 5 | Current micro-address |

## Verification
Two functions can fall in the same clock period:

- A jump word can decide its branch at the rising edge, and in the same period the control register must hold through the falling edge.
- A do word at address 31 can load `ctl` at the falling edge, and then wrap the micro-PC to 0 at the next rising edge.

A test program places a polling jump directly after output words, and a chain of jumps leading into addresses 30 and 31. A mix of steady and shifting `z` values then drives each condition code through both of its outcomes. A reference interpreter in the bench steps through the same program every cycle. `upc` and `ctl` are judged against it shortly after each falling edge. `ctl` is also compared across each rising edge to confirm it does not move there.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic {
        WK_DO   = 1'b0,
        WK_JUMP = 1'b1
    } word_kind_e;

    typedef enum logic [1:0] {
        CC_IF_Z   = 2'b00,
        CC_IF_NZ  = 2'b01,
        CC_NEVER  = 2'b10,
        CC_ALWAYS = 2'b11
    } cond_e;

    typedef enum logic [1:0] {
        STEP_ADVANCE = 2'b00,
        STEP_BRANCH  = 2'b01,
        STEP_SKIP    = 2'b10
    } step_e;

endpackage

// File: rtl/useq_rom.sv
module useq_rom #(
    parameter int ADDR_W = 5,
    parameter int WORD_W = 8,
    parameter int DEPTH  = 32,
    parameter logic [DEPTH*WORD_W-1:0] PROG = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        word = PROG[addr*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int WORD_W = 8,
    parameter int OUT_W  = 7
) (
    input  logic [WORD_W-1:0] word,
    input  logic              z,
    output word_kind_e        kind,
    output cond_e             cond,
    output logic [ADDR_W-1:0] target,
    output logic [OUT_W-1:0]  do_bits,
    output step_e             step
);
    localparam int KIND_BIT = WORD_W - 1;
    localparam int COND_LO  = ADDR_W;

    always_comb begin
        kind    = word_kind_e'(word[KIND_BIT]);
        cond    = cond_e'(word[COND_LO +: 2]);
        target  = word[ADDR_W-1:0];
        do_bits = word[OUT_W-1:0];
    end

    always_comb begin
        step = STEP_ADVANCE;
        unique case (kind)
            WK_DO: step = STEP_ADVANCE;
            WK_JUMP: begin
                unique case (cond)
                    CC_IF_Z:   step = z  ? STEP_BRANCH : STEP_SKIP;
                    CC_IF_NZ:  step = !z ? STEP_BRANCH : STEP_SKIP;
                    CC_NEVER:  step = STEP_SKIP;
                    CC_ALWAYS: step = STEP_BRANCH;
                    default:   step = STEP_SKIP;
                endcase
            end
            default: step = STEP_ADVANCE;
        endcase
    end
endmodule

// File: rtl/useq_upc.sv
module useq_upc
    import useq_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_e             step,
    input  word_kind_e        kind,
    input  cond_e             cond,
    input  logic              z,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] upc
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upc <= '0;
        end else begin
            unique case (step)
                STEP_BRANCH:  upc <= target;
                STEP_ADVANCE: upc <= upc + 1'b1;
                STEP_SKIP:    upc <= upc + 1'b1;
                default:      upc <= upc + 1'b1;
            endcase
        end
    end

    assert_reset_upc_R1: assert property (@(posedge clk) !rst_n |-> upc == '0);

    assert_do_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_DO) |=> (upc == $past(upc) + 1'b1));

    assert_ifz_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_JUMP && cond == CC_IF_Z && z) |=> (upc == $past(target)));

    assert_ifnz_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_JUMP && cond == CC_IF_NZ && !z) |=> (upc == $past(target)));

    assert_always_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_JUMP && cond == CC_ALWAYS) |=> (upc == $past(target)));

    assert_never_skips_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_JUMP && cond == CC_NEVER) |=> (upc == $past(upc) + 1'b1));

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_DO && upc == TOP_ADDR) |=> (upc == '0));
endmodule

// File: rtl/useq_outreg.sv
module useq_outreg
    import useq_pkg::*;
#(
    parameter int OUT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  word_kind_e       kind,
    input  logic [OUT_W-1:0] do_bits,
    output logic [OUT_W-1:0] ctl
);
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl <= '0;
        end else begin
            unique case (kind)
                WK_DO:   ctl <= do_bits;
                WK_JUMP: ctl <= ctl;
                default: ctl <= ctl;
            endcase
        end
    end

    assert_reset_ctl_R1: assert property (@(negedge clk) !rst_n |-> ctl == '0);

    assert_do_loads_R8: assert property (@(negedge clk) disable iff (!rst_n)
        (kind == WK_DO) |=> (ctl == $past(do_bits)));

    assert_jump_holds_R9: assert property (@(negedge clk) disable iff (!rst_n)
        (kind == WK_JUMP) |=> (ctl == $past(ctl)));
endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int WORD_W = 8,
    parameter logic [(1<<ADDR_W)*WORD_W-1:0] PROG =
        256'h0000000000000000000000E08E00E08701EFE08E01EB8700E8F28700E4E08300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              z,
    output logic [WORD_W-2:0] ctl,
    output logic [ADDR_W-1:0] upc
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int OUT_W = WORD_W - 1;

    logic [WORD_W-1:0] cur_word;
    word_kind_e        kind;
    cond_e             cond;
    logic [ADDR_W-1:0] target;
    logic [OUT_W-1:0]  do_bits;
    step_e             step;

    useq_rom #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .DEPTH(DEPTH), .PROG(PROG)) u_rom (
        .addr (upc),
        .word (cur_word)
    );

    useq_decode #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .OUT_W(OUT_W)) u_dec (
        .word    (cur_word),
        .z       (z),
        .kind    (kind),
        .cond    (cond),
        .target  (target),
        .do_bits (do_bits),
        .step    (step)
    );

    useq_upc #(.ADDR_W(ADDR_W)) u_upc (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .kind   (kind),
        .cond   (cond),
        .z      (z),
        .target (target),
        .upc    (upc)
    );

    useq_outreg #(.OUT_W(OUT_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .do_bits (do_bits),
        .ctl     (ctl)
    );
endmodule

// File: tb/tb_useq_top.sv
`timescale 1ns/1ps
module tb_useq_top;
    localparam int AW = 5;
    localparam int WW = 8;
    // test program, address 31 in the top byte
    localparam logic [255:0] TPROG =
        {8'h15, 8'h40, 160'h0, 8'hE6, 8'h33, 8'hFE, 8'h01, 8'h88,
         8'h7F, 8'hC0, 8'h2A, 8'hA4, 8'h55};
    localparam logic [255:0] FPROG =
        256'h0000000000000000000000E08E00E08701EFE08E01EB8700E8F28700E4E08300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic z_t = 1'b0, z_f = 1'b0;
    logic [6:0] ctl_t, ctl_f;
    logic [4:0] upc_t, upc_f;

    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    useq_top #(.ADDR_W(AW), .WORD_W(WW), .PROG(TPROG)) dut (
        .clk(clk), .rst_n(rst_n), .z(z_t), .ctl(ctl_t), .upc(upc_t));
    useq_top #(.ADDR_W(AW), .WORD_W(WW)) dut_fsm (
        .clk(clk), .rst_n(rst_n), .z(z_f), .ctl(ctl_f), .upc(upc_f));

    // reference model state
    int m_upc_t, m_ctl_t, m_upc_f, m_ctl_f;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int wd(input logic [255:0] p, input int a);
        return int'(p[a*8 +: 8]);
    endfunction

    // next address per R2..R7; also returns tag
    function automatic int nxt(input int w, input int a, input bit zz, output string tag);
        int c;
        bit take;
        if (w < 128) begin tag = (a == 31) ? "R7" : "R2"; return (a + 1) % 32; end
        c = (w >> 5) & 3;
        case (c)
            0: begin take = zz;  tag = "R3"; end
            1: begin take = !zz; tag = "R4"; end
            2: begin take = 0;   tag = "R6"; end
            default: begin take = 1; tag = "R5"; end
        endcase
        if (take) return w & 31;
        if (a == 31) tag = "R7";
        return (a + 1) % 32;
    endfunction

    function automatic int outv(input int w, input int old);
        return (w < 128) ? (w & 127) : old;
    endfunction

    task automatic step(input bit zt, input bit zf);
        string tt, tf, ct;
        int pre_t, pre_f, w;
        z_t = zt; z_f = zf;
        pre_t = int'(ctl_t); pre_f = int'(ctl_f);
        @(posedge clk);
        m_upc_t = nxt(wd(TPROG, m_upc_t), m_upc_t, zt, tt);
        m_upc_f = nxt(wd(FPROG, m_upc_f), m_upc_f, zf, tf);
        #2;
        chk(int'(ctl_t) == pre_t, "R10", int'(ctl_t), pre_t);
        chk(int'(ctl_f) == pre_f, "R10", int'(ctl_f), pre_f);
        @(negedge clk);
        w = wd(TPROG, m_upc_t);
        ct = (w < 128) ? "R8" : "R9";
        m_ctl_t = outv(w, m_ctl_t);
        m_ctl_f = outv(wd(FPROG, m_upc_f), m_ctl_f);
        #5;
        chk(int'(upc_t) == m_upc_t, tt, int'(upc_t), m_upc_t);
        chk(int'(ctl_t) == m_ctl_t, ct, int'(ctl_t), m_ctl_t);
        chk(int'(upc_f) == m_upc_f, "R11", int'(upc_f), m_upc_f);
        chk(int'(ctl_f) == m_ctl_f, "R11", int'(ctl_f), m_ctl_f);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        #3;
        chk(upc_t == 0 && ctl_t == 0, "R1", int'({upc_t, ctl_t}), 0);
        chk(upc_f == 0 && ctl_f == 0, "R1", int'({upc_f, ctl_f}), 0);
        @(negedge clk); #5;
        rst_n = 1'b1;
        m_upc_t = 0; m_ctl_t = 0; m_upc_f = 0; m_ctl_f = 0;
    endtask

    initial begin
        bit [5:0] seq;
        logic [7:0] lfsr;
        seq = 6'b101101;
        lfsr = 8'hA5;
        @(negedge clk); @(negedge clk); #5;
        do_reset();
        // R11: z sequence 1,0,1,1,0,1 each held four cycles; test program sees steady z
        for (int i = 5; i >= 0; i--)
            for (int k = 0; k < 4; k++) step(1'b1, seq[i]);
        for (int k = 0; k < 40; k++) step(1'b0, 1'b0);
        for (int k = 0; k < 40; k++) step(1'b1, 1'b1);
        do_reset();
        for (int i = 5; i >= 0; i--)
            for (int k = 0; k < 4; k++) step(seq[i], seq[i]);
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[0], lfsr[3]);
        end
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule